// File: doc/BRIEF.md
# Character Display Controller Host Port

This block is the parallel host-facing port of a character display controller. A host processor drives an enable strobe, a register-select line, a read/write line and an 8-bit bidirectional data bus. Each strobe is one of four accesses: an instruction write, a status read, a data write or a data read. The block keeps an instruction register and a data register. It reports a busy flag together with the core's address counter, and it hands every decoded instruction or data byte to an execution core over a valid/ready handshake.

The port works with an 8-bit bus or a 4-bit bus, chosen by a width bit that the core supplies. In 4-bit mode every byte takes two strobes on the upper four data lines, upper nibble first. Data reads are served from the data register. After each data read the block asks the core for the next byte, and the core reloads the data register with it. A data read that follows no address-set instruction therefore returns whatever the data register already held. The enable strobe is asynchronous to the system clock. It is synchronised, and its falling edge completes each transfer.

Top module: `chr_host_port`

## Requirements
- R1: Each strobe is decoded by {rs,rw}: 00 writes the instruction register, 01 reads status, 10 writes the data register, 11 reads the data register.
- R2: A status read returns the busy flag on bit 7 and the core address on bits 6:0. Busy is 1 while a command is pending or while core_busy is high.
- R3: With wide_mode=1, each strobe transfers a whole byte on data lines 7:0.
- R4: With wide_mode=0, only lines 7:4 carry data. Each byte takes two strobes, upper nibble first. Reads drive the upper nibble, then the lower nibble, on lines 7:4 and leave lines 3:0 undriven.
- R5: In 4-bit mode, no command is raised after the first nibble. A command is raised, and busy goes high, only once the second nibble has completed.
- R6: The nibble phase returns to "upper" at reset and whenever wide_mode changes.
- R7: A command is raised on cmd_kind/cmd_byte. An instruction write gives kind 0 with the instruction byte. A data write gives kind 1 with the written byte. A data read gives kind 2 (next-byte fetch) with the byte just returned.
- R8: cmd_valid holds, with cmd_kind and cmd_byte stable, until cmd_ready is seen. Any access that completes while a command is pending is dropped.
- R9: A pulse on load_valid loads load_byte into the data register, and data reads return that register. A status read never returns the instruction register.
- R10: The block drives the data bus only while host_en is high and host_rw is 1. At all other times the bus is high impedance.
- R11: After reset, no command is pending, the bus is released and the status busy bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Host enable strobe, asynchronous |
| host_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| host_rw | input | 1 | 1 read, 0 write |
| host_d | inout | 8 | Bidirectional host data bus |
| wide_mode | input | 1 | Bus width: 1 for 8-bit, 0 for 4-bit |
| core_busy | input | 1 | Core is executing |
| core_addr | input | 7 | Core address counter |
| cmd_valid | output | 1 | Command pending to the core |
| cmd_ready | input | 1 | Core accepts the command |
| cmd_kind | output | 2 | 0 instruction, 1 data write, 2 next-byte fetch |
| cmd_byte | output | 8 | Command payload |
| load_valid | input | 1 | Core loads the data register |
| load_byte | input | 8 | Byte for the data register |

## Verification
Read data appears combinationally once the strobe rises, because it comes from registers that are already stable. The bench samples it on a falling clock edge a few cycles into the strobe. A write or a fetch request reaches cmd_valid four clock edges after the strobe falls: two synchroniser stages, an edge register and the nibble/byte register. Every strobe is therefore followed by eight idle cycles before the next action. A scoreboard holds the expected commands and pops one at each accepted handshake, so commands that are dropped or raised early both show up as mismatches. The checks on nibble pairing read cmd_valid directly between the two strobes of a byte.

// File: rtl/chr_host_pkg.sv
package chr_host_pkg;
  typedef enum logic [1:0] {
    CMD_INSTR = 2'd0,
    CMD_WDATA = 2'd1,
    CMD_FETCH = 2'd2
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ACC_IWR  = 2'b00,
    ACC_STAT = 2'b01,
    ACC_DWR  = 2'b10,
    ACC_DRD  = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/chr_reset_sync.sv
module chr_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/chr_strobe_sync.sv
module chr_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_async,
  output logic fall_o
);
  logic [STAGES:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= {hist_q[STAGES-1:0], en_async};
  end

  assign fall_o = hist_q[STAGES] & ~hist_q[STAGES-1];
endmodule

// File: rtl/chr_nibble_pack.sv
module chr_nibble_pack #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              wide,
  input  logic              rs,
  input  logic              rw,
  input  logic [DATA_W-1:0] din,
  output logic              acc_done,
  output logic              acc_rs,
  output logic              acc_rw,
  output logic [DATA_W-1:0] acc_byte,
  output logic              phase_o
);
  localparam int NIB_W = DATA_W / 2;

  logic              phase_q, phase_d;
  logic              wide_q;
  logic [NIB_W-1:0]  hi_q, hi_d;
  logic              done_q, done_d;
  logic              rs_q, rs_d, rw_q, rw_d;
  logic [DATA_W-1:0] byte_q, byte_d;

  always_comb begin
    phase_d = phase_q;
    hi_d    = hi_q;
    done_d  = 1'b0;
    rs_d    = rs_q;
    rw_d    = rw_q;
    byte_d  = byte_q;
    if (wide != wide_q) begin
      phase_d = 1'b0;
    end else if (fall) begin
      if (wide) begin
        done_d = 1'b1;
        byte_d = din;
        rs_d   = rs;
        rw_d   = rw;
      end else if (!phase_q) begin
        phase_d = 1'b1;
        hi_d    = din[DATA_W-1:NIB_W];
      end else begin
        phase_d = 1'b0;
        done_d  = 1'b1;
        byte_d  = {hi_q, din[DATA_W-1:NIB_W]};
        rs_d    = rs;
        rw_d    = rw;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      wide_q  <= 1'b1;
      hi_q    <= '0;
      done_q  <= 1'b0;
      rs_q    <= 1'b0;
      rw_q    <= 1'b0;
      byte_q  <= '0;
    end else begin
      phase_q <= phase_d;
      wide_q  <= wide;
      hi_q    <= hi_d;
      done_q  <= done_d;
      rs_q    <= rs_d;
      rw_q    <= rw_d;
      byte_q  <= byte_d;
    end
  end

  assign acc_done = done_q;
  assign acc_rs   = rs_q;
  assign acc_rw   = rw_q;
  assign acc_byte = byte_q;
  assign phase_o  = phase_q;

  assert_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && !$past(wide_q)) |-> $past(phase_q));

  assert_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && $past(wide)) |-> !phase_q);
endmodule

// File: rtl/chr_cmd_stage.sv
module chr_cmd_stage
  import chr_host_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_done,
  input  logic              acc_rs,
  input  logic              acc_rw,
  input  logic [DATA_W-1:0] acc_byte,
  input  logic              cmd_ready,
  input  logic              load_valid,
  input  logic [DATA_W-1:0] load_byte,
  output logic              cmd_valid,
  output logic [1:0]        cmd_kind,
  output logic [DATA_W-1:0] cmd_byte,
  output logic [DATA_W-1:0] dr_o
);
  logic              pend_q, pend_d;
  cmd_kind_e         kind_q, kind_d;
  logic [DATA_W-1:0] ir_q, ir_d;
  logic [DATA_W-1:0] dr_q, dr_d;
  acc_kind_e         acc;

  assign acc = acc_kind_e'({acc_rs, acc_rw});

  always_comb begin
    pend_d = pend_q;
    kind_d = kind_q;
    ir_d   = ir_q;
    dr_d   = dr_q;
    if (pend_q && cmd_ready) pend_d = 1'b0;
    if (load_valid)          dr_d   = load_byte;
    if (acc_done && !pend_q) begin
      case (acc)
        ACC_IWR: begin
          ir_d   = acc_byte;
          pend_d = 1'b1;
          kind_d = CMD_INSTR;
        end
        ACC_DWR: begin
          dr_d   = acc_byte;
          pend_d = 1'b1;
          kind_d = CMD_WDATA;
        end
        ACC_DRD: begin
          pend_d = 1'b1;
          kind_d = CMD_FETCH;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      kind_q <= CMD_INSTR;
      ir_q   <= '0;
      dr_q   <= '0;
    end else begin
      pend_q <= pend_d;
      kind_q <= kind_d;
      ir_q   <= ir_d;
      dr_q   <= dr_d;
    end
  end

  assign cmd_valid = pend_q;
  assign cmd_kind  = kind_q;
  assign cmd_byte  = (kind_q == CMD_INSTR) ? ir_q : dr_q;
  assign dr_o      = dr_q;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_byte) && $stable(cmd_kind)));

  assert_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(acc_done));
endmodule

// File: rtl/chr_host_port.sv
module chr_host_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              host_en,
  input  logic              host_rs,
  input  logic              host_rw,
  inout  wire  [DATA_W-1:0] host_d,
  input  logic              wide_mode,
  input  logic              core_busy,
  input  logic [DATA_W-2:0] core_addr,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_kind,
  output logic [DATA_W-1:0] cmd_byte,
  input  logic              load_valid,
  input  logic [DATA_W-1:0] load_byte
);
  localparam int NIB_W = DATA_W / 2;

  logic              rst_n;
  logic              fall;
  logic              acc_done, acc_rs, acc_rw, phase;
  logic [DATA_W-1:0] acc_byte, dr, status, rd_val;
  logic [NIB_W-1:0]  hi_out;
  logic              drive;

  chr_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n_o(rst_n));

  chr_strobe_sync #(.STAGES(SYNC_STAGES)) u_strobe (
    .clk(clk), .rst_n(rst_n), .en_async(host_en), .fall_o(fall));

  chr_nibble_pack #(.DATA_W(DATA_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .fall(fall), .wide(wide_mode),
    .rs(host_rs), .rw(host_rw), .din(host_d),
    .acc_done(acc_done), .acc_rs(acc_rs), .acc_rw(acc_rw),
    .acc_byte(acc_byte), .phase_o(phase));

  chr_cmd_stage #(.DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .acc_done(acc_done), .acc_rs(acc_rs),
    .acc_rw(acc_rw), .acc_byte(acc_byte), .cmd_ready(cmd_ready),
    .load_valid(load_valid), .load_byte(load_byte),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_byte(cmd_byte),
    .dr_o(dr));

  assign status = {core_busy | cmd_valid, core_addr};
  assign rd_val = host_rs ? dr : status;
  assign drive  = host_en & host_rw;
  assign hi_out = (!wide_mode && phase) ? rd_val[NIB_W-1:0] : rd_val[DATA_W-1:NIB_W];

  assign host_d[DATA_W-1:NIB_W] = drive ? hi_out : 'z;
  assign host_d[NIB_W-1:0]      = (drive && wide_mode) ? rd_val[NIB_W-1:0] : 'z;
endmodule

// File: tb/chr_host_port_tb.sv
module chr_host_port_tb;
  logic       clk = 1'b0;
  logic       arst_n, host_en, host_rs, host_rw, wide_mode, core_busy;
  logic       cmd_ready, load_valid;
  logic [7:0] load_byte, hdrv;
  logic       hoe;
  logic [6:0] m_addr;
  wire  [7:0] host_d;
  logic       cmd_valid;
  logic [1:0] cmd_kind;
  logic [7:0] cmd_byte;
  logic [7:0] mem [128];
  logic [9:0] exp_q [$];
  int         n_chk = 0, n_bad = 0;
  logic       run_done = 1'b0;

  always #10 clk = ~clk;

  assign host_d = hoe ? hdrv : 'z;

  chr_host_port u_dut (
    .clk(clk), .arst_n(arst_n), .host_en(host_en), .host_rs(host_rs),
    .host_rw(host_rw), .host_d(host_d), .wide_mode(wide_mode),
    .core_busy(core_busy), .core_addr(m_addr), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_byte(cmd_byte),
    .load_valid(load_valid), .load_byte(load_byte));

  task automatic check(input logic ok, input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // core model and scoreboard monitor
  always @(negedge clk) begin
    load_valid = 1'b0;
    if (arst_n && cmd_valid && cmd_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected command", {cmd_kind, cmd_byte}, 10'h0);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        check({cmd_kind, cmd_byte} === e, "R7 command", {cmd_kind, cmd_byte}, e);
      end
      case (cmd_kind)
        2'd0: if (cmd_byte[7]) begin
          m_addr = cmd_byte[6:0];
          load_valid = 1'b1; load_byte = mem[m_addr];
        end
        2'd1: begin mem[m_addr] = cmd_byte; m_addr = m_addr + 7'd1; end
        2'd2: begin
          m_addr = m_addr + 7'd1;
          load_valid = 1'b1; load_byte = mem[m_addr];
        end
        default: ;
      endcase
    end
  end

  task automatic strobe();
    @(negedge clk); host_en = 1'b1;
    repeat (3) @(negedge clk);
    host_en = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic wr8(input logic rs, input logic [7:0] b);
    host_rs = rs; host_rw = 1'b0; hdrv = b; hoe = 1'b1;
    strobe();
    hoe = 1'b0;
  endtask

  task automatic wr_nib(input logic rs, input logic [3:0] n);
    host_rs = rs; host_rw = 1'b0; hdrv = {n, 4'h0}; hoe = 1'b1;
    strobe();
    hoe = 1'b0;
  endtask

  task automatic rd(input logic rs, output logic [7:0] v);
    host_rs = rs; host_rw = 1'b1; hoe = 1'b0;
    @(negedge clk); host_en = 1'b1;
    repeat (3) @(negedge clk);
    v = host_d;
    host_en = 1'b0;
    repeat (8) @(negedge clk);
    host_rw = 1'b0;
  endtask

  task automatic push(input logic [1:0] k, input logic [7:0] b);
    exp_q.push_back({k, b});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!run_done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    arst_n = 1'b0; host_en = 1'b0; host_rs = 1'b0; host_rw = 1'b0;
    wide_mode = 1'b1; core_busy = 1'b0; cmd_ready = 1'b1;
    load_valid = 1'b0; load_byte = '0; hdrv = '0; hoe = 1'b0; m_addr = '0;
    for (int i = 0; i < 128; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (5) @(negedge clk);
    arst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 reset state, R10 bus released
    check(cmd_valid == 1'b0, "R11 no pending", {1'b0, cmd_valid}, 10'h0);
    check(host_d === 8'hzz, "R10 bus idle", {2'b0, host_d}, 10'h0);
    rd(1'b0, v);
    check(v == 8'h00, "R11 status after reset", {2'b0, v}, 10'h000);

    // R1 R3 instruction write, R9 status never shows IR
    push(2'd0, 8'h85);
    wr8(1'b0, 8'h85);
    rd(1'b0, v);
    check(v == 8'h05, "R9 status not instruction", {2'b0, v}, 10'h005);

    // R7 data write commits
    push(2'd1, 8'h41);
    wr8(1'b1, 8'h41);
    rd(1'b0, v);
    check(v == 8'h06, "R2 address field", {2'b0, v}, 10'h006);

    // R8 pending command holds, busy shows, further access dropped
    cmd_ready = 1'b0;
    push(2'd1, 8'h42);
    wr8(1'b1, 8'h42);
    check(cmd_valid && cmd_kind == 2'd1 && cmd_byte == 8'h42, "R8 held command",
          {cmd_kind, cmd_byte}, {2'd1, 8'h42});
    rd(1'b0, v);
    check(v == 8'h86, "R2 busy bit set", {2'b0, v}, 10'h086);
    wr8(1'b1, 8'h99);
    check(cmd_byte == 8'h42, "R8 dropped access", {2'b0, cmd_byte}, 10'h042);
    cmd_ready = 1'b1;
    repeat (3) @(negedge clk);
    rd(1'b0, v);
    check(v == 8'h07, "R8 busy clears", {2'b0, v}, 10'h007);

    // R9 data read with prefetch
    push(2'd0, 8'h85);
    wr8(1'b0, 8'h85);
    push(2'd2, 8'h41);
    rd(1'b1, v);
    check(v == 8'h41, "R9 read data", {2'b0, v}, 10'h041);
    push(2'd2, 8'h42);
    rd(1'b1, v);
    check(v == 8'h42, "R9 prefetched read", {2'b0, v}, 10'h042);

    // R10 idle bus with rw high and low
    host_rw = 1'b1; @(negedge clk);
    check(host_d === 8'hzz, "R10 rw high enable low", {2'b0, host_d}, 10'h0);
    host_rw = 1'b0; @(negedge clk);
    check(host_d === 8'hzz, "R10 rw low", {2'b0, host_d}, 10'h0);

    // R4 R5 nibble mode write
    wide_mode = 1'b0;
    repeat (4) @(negedge clk);
    cmd_ready = 1'b0;
    wr_nib(1'b0, 4'h8);
    check(cmd_valid == 1'b0, "R5 nothing after first nibble", {1'b0, cmd_valid}, 10'h0);
    wr_nib(1'b0, 4'h5);
    check(cmd_valid && cmd_byte == 8'h85, "R4 paired byte", {cmd_kind, cmd_byte}, {2'd0, 8'h85});
    push(2'd0, 8'h85);
    cmd_ready = 1'b1;
    repeat (3) @(negedge clk);

    // R4 nibble status read
    rd(1'b0, v);
    check(v[7:4] == 4'h0 && v[3:0] === 4'hz, "R4 status upper nibble", {2'b0, v}, 10'h00);
    rd(1'b0, v2);
    check(v2[7:4] == 4'h5, "R4 status lower nibble", {6'b0, v2[7:4]}, 10'h5);

    // R4 R9 nibble data read
    push(2'd2, 8'h41);
    rd(1'b1, v);
    rd(1'b1, v2);
    check({v[7:4], v2[7:4]} == 8'h41, "R4 data nibbles", {2'b0, v[7:4], v2[7:4]}, 10'h041);

    // R6 width change restarts pairing
    wr_nib(1'b0, 4'h8);
    wide_mode = 1'b1; repeat (3) @(negedge clk);
    wide_mode = 1'b0; repeat (3) @(negedge clk);
    push(2'd0, 8'h87);
    wr_nib(1'b0, 4'h8);
    wr_nib(1'b0, 4'h7);
    rd(1'b0, v);
    rd(1'b0, v2);
    check({v[7:4], v2[7:4]} == 8'h07, "R6 phase reset", {2'b0, v[7:4], v2[7:4]}, 10'h007);

    // R3 back in 8-bit mode
    wide_mode = 1'b1;
    repeat (4) @(negedge clk);
    push(2'd1, 8'h33);
    wr8(1'b1, 8'h33);
    push(2'd0, 8'h87);
    wr8(1'b0, 8'h87);
    push(2'd2, 8'h33);
    rd(1'b1, v);
    check(v == 8'h33, "R3 full byte read", {2'b0, v}, 10'h033);

    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R7 all commands seen", 10'(exp_q.size()), 10'h0);

    run_done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule